// File: doc/BRIEF.md
# Capacitive Key Detection Filter

This block turns the raw pulse count of one capacitive sensing channel into a clean touched or released decision. After every acquisition the count arrives with a one-cycle valid strobe. The block keeps a reference level for the key. A touch lowers the count below that reference, and the distance between them is the touch signal. A touch is declared when the signal passes a detection threshold for a programmed run of consecutive samples. The touch ends when the signal falls back to a lower release threshold for its own run, so the two thresholds form a hysteresis band.

The reference comes from an eight-sample average when the key is enabled or recalibrated. While the key is released the reference follows slow drift, quickly when the count rises and slowly when it falls, and it stays frozen while a touch is held. A sustained large rise of the count restarts calibration. So does a touch held longer than a programmable limit. A count outside the allowed window marks the key faulty and takes it out of processing until software forces a recalibration. One output pulse reports every change of the touch state, the end of each calibration and the entry into the fault state.

The controller states are Off (key disabled), Calibrate, Released, Touched and Fault. Its transitions are: Off to Calibrate on enable; Calibrate to Released on the eighth good sample; Released to Touched on a complete detection run; Touched to Released on a complete release run; Released to Calibrate on a complete rise run; Touched to Calibrate on timeout; Calibrate, Released or Touched to Fault on an out-of-range sample; any enabled state to Calibrate on a recalibration request; any state to Off when the enable drops.

Top module: `touch_key_filter`

## Requirements
- R1: After reset, and in the cycle after `key_en` is seen low, `touched`, `cal_busy`, `err_flags` and `change_pulse` are all 0, and samples are ignored. A disable never produces `change_pulse`. When `key_en` is seen high in the Off state, calibration starts.
- R2: Calibration takes 8 accepted in-range samples. The reference becomes floor(sum/8). During calibration `cal_busy` and `err_flags` bit 0 are 1. The eighth sample ends calibration in the Released state with a `change_pulse`.
- R3: In Released, a sample qualifies for detection when `reference - count > det_thr`. After `det_len+1` consecutive qualifying samples `touched` rises with a `change_pulse`. Any non-qualifying sample restarts the run.
- R4: In Touched, a sample qualifies for release when `reference - count <= rel_thr`. After `rel_len+1` consecutive qualifying samples `touched` falls with a `change_pulse`. A non-qualifying sample restarts the run.
- R5: Drift applies only to in-range samples in Released that do not qualify for detection. A count above the reference for `drift_up_div` consecutive such samples raises the reference by 1. A count below it for `drift_dn_div` consecutive such samples lowers it by 1. A count equal to the reference clears both runs. A detection-qualifying sample clears both runs, and the reference stays fixed in Touched. A divisor of 0 disables that direction.
- R6: In Released, `count - reference > rise_thr` for `rise_len+1` consecutive samples restarts calibration without a `change_pulse`.
- R7: In Touched, when the `max_on`-th sample after entry does not release, the key drops `touched` with a `change_pulse` and recalibrates. With `max_on` = 0 the touch is held indefinitely. A completing release run takes priority over the timeout.
- R8: A sample with count > `cnt_max` sets `err_flags` bit 1. A sample with count < `cnt_min` sets bit 2. In Calibrate, Released or Touched such a sample enters Fault with `touched` = 0 and a `change_pulse`. In Fault, samples are ignored and the flag holds.
- R9: `recal_req` with `key_en` high restarts calibration from any state in the next cycle and clears the fault flags. A sample in the same cycle is dropped. If the key was touched, `change_pulse` fires.
- R10: Every output reflects the clock edge that sampled its cause and appears in the following cycle. `change_pulse` is high for exactly one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_en | input | 1 | Key enable |
| recal_req | input | 1 | Recalibration request pulse |
| sample_vld | input | 1 | Acquisition result strobe |
| sample_cnt | input | CNT_W | Burst pulse count |
| det_thr | input | THR_W | Detection threshold |
| rel_thr | input | THR_W | Release threshold |
| rise_thr | input | THR_W | Recalibration rise threshold |
| det_len | input | RUN_W | Detection run length minus one |
| rel_len | input | RUN_W | Release run length minus one |
| rise_len | input | RUN_W | Rise run length minus one |
| drift_up_div | input | DIV_W | Samples per upward reference step (0 = off) |
| drift_dn_div | input | DIV_W | Samples per downward reference step (0 = off) |
| max_on | input | TMO_W | Touch timeout in samples (0 = never) |
| cnt_min | input | CNT_W | Lowest in-range count |
| cnt_max | input | CNT_W | Highest in-range count |
| touched | output | 1 | Key touched |
| cal_busy | output | 1 | Calibration in progress |
| err_flags | output | 3 | bit0 calibrating, bit1 count too high, bit2 count too low |
| change_pulse | output | 1 | One-cycle event pulse |

## Verification
Each result of a sample is due exactly one cycle after the clock edge that takes the strobe. That covers the touch state, the calibration flag, the error flags and the event pulse. A recalibration request or an enable change also shows its effect one cycle later. The driver holds each input for one cycle from a falling edge and queues the expected outputs. The monitor waits for the rising edge that samples the strobe, compares at the next falling edge, and one falling edge after that confirms the pulse has cleared. The reference is never read directly. It is inferred from the sample counts at which detection does or does not occur, one count either side of the threshold.

// File: rtl/tkf_pkg.sv
package tkf_pkg;
    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_CAL   = 3'd1,
        ST_IDLE  = 3'd2,
        ST_TOUCH = 3'd3,
        ST_FAULT = 3'd4
    } key_state_e;

    localparam int CAL_LOG2 = 3;   // eight samples per calibration
    localparam int RUN_NUM  = 3;
    localparam int RUN_DET  = 0;
    localparam int RUN_REL  = 1;
    localparam int RUN_RISE = 2;
endpackage

// File: rtl/tkf_run_len.sv
module tkf_run_len #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             qual,
    input  logic [LEN_W-1:0] len,
    output logic             done
);
    logic [LEN_W-1:0] run_q;

    // run_q counts earlier qualifying samples, so equality marks sample len+1
    assign done = step && qual && (run_q == len);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (clr || (step && (!qual || done))) begin
            run_q <= '0;
        end else if (step) begin
            run_q <= run_q + LEN_W'(1);
        end
    end
endmodule

// File: rtl/tkf_ref_track.sv
module tkf_ref_track #(
    parameter int CNT_W    = 12,
    parameter int DIV_W    = 8,
    parameter int CAL_LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cal_start,
    input  logic             cal_step,
    input  logic             drift_step,
    input  logic             drift_clr,
    input  logic [CNT_W-1:0] cnt,
    input  logic [DIV_W-1:0] up_div,
    input  logic [DIV_W-1:0] dn_div,
    output logic [CNT_W-1:0] ref_lvl,
    output logic             cal_done
);
    localparam int CAL_N = 1 << CAL_LOG2;
    localparam int ACC_W = CNT_W + CAL_LOG2;

    logic [ACC_W-1:0]    acc_q;
    logic [ACC_W-1:0]    acc_sum;
    logic [CAL_LOG2-1:0] idx_q;
    logic [DIV_W-1:0]    up_run_q;
    logic [DIV_W-1:0]    dn_run_q;
    logic                up_hit;
    logic                dn_hit;

    assign acc_sum  = acc_q + ACC_W'(cnt);
    assign cal_done = cal_step && (idx_q == CAL_LOG2'(CAL_N - 1));
    assign up_hit   = (up_div != '0) && ((up_run_q + DIV_W'(1)) == up_div);
    assign dn_hit   = (dn_div != '0) && ((dn_run_q + DIV_W'(1)) == dn_div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_lvl  <= '0;
            acc_q    <= '0;
            idx_q    <= '0;
            up_run_q <= '0;
            dn_run_q <= '0;
        end else if (cal_start) begin
            acc_q    <= '0;
            idx_q    <= '0;
            up_run_q <= '0;
            dn_run_q <= '0;
        end else if (cal_step) begin
            if (cal_done) begin
                ref_lvl <= acc_sum[ACC_W-1:CAL_LOG2];
                acc_q   <= '0;
                idx_q   <= '0;
            end else begin
                acc_q <= acc_sum;
                idx_q <= idx_q + CAL_LOG2'(1);
            end
        end else if (drift_clr) begin
            up_run_q <= '0;
            dn_run_q <= '0;
        end else if (drift_step) begin
            if (cnt > ref_lvl) begin
                dn_run_q <= '0;
                if (up_div == '0) begin
                    up_run_q <= '0;
                end else if (up_hit) begin
                    ref_lvl  <= ref_lvl + CNT_W'(1);
                    up_run_q <= '0;
                end else begin
                    up_run_q <= up_run_q + DIV_W'(1);
                end
            end else if (cnt < ref_lvl) begin
                up_run_q <= '0;
                if (dn_div == '0) begin
                    dn_run_q <= '0;
                end else if (dn_hit) begin
                    ref_lvl  <= ref_lvl - CNT_W'(1);
                    dn_run_q <= '0;
                end else begin
                    dn_run_q <= dn_run_q + DIV_W'(1);
                end
            end else begin
                up_run_q <= '0;
                dn_run_q <= '0;
            end
        end
    end
endmodule

// File: rtl/tkf_on_timer.sv
module tkf_on_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [TMO_W-1:0] limit,
    output logic             expire
);
    logic [TMO_W-1:0] on_q;

    assign expire = step && (limit != '0) && ((on_q + TMO_W'(1)) == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_q <= '0;
        end else if (clr) begin
            on_q <= '0;
        end else if (step && !expire) begin
            on_q <= on_q + TMO_W'(1);
        end
    end
endmodule

// File: rtl/touch_key_filter.sv
module touch_key_filter
    import tkf_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int THR_W = 8,
    parameter int RUN_W = 4,
    parameter int DIV_W = 8,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_en,
    input  logic             recal_req,
    input  logic             sample_vld,
    input  logic [CNT_W-1:0] sample_cnt,
    input  logic [THR_W-1:0] det_thr,
    input  logic [THR_W-1:0] rel_thr,
    input  logic [THR_W-1:0] rise_thr,
    input  logic [RUN_W-1:0] det_len,
    input  logic [RUN_W-1:0] rel_len,
    input  logic [RUN_W-1:0] rise_len,
    input  logic [DIV_W-1:0] drift_up_div,
    input  logic [DIV_W-1:0] drift_dn_div,
    input  logic [TMO_W-1:0] max_on,
    input  logic [CNT_W-1:0] cnt_min,
    input  logic [CNT_W-1:0] cnt_max,
    output logic             touched,
    output logic             cal_busy,
    output logic [2:0]       err_flags,
    output logic             change_pulse
);
    localparam int SIG_W = CNT_W + 1;
    localparam int PAD_W = SIG_W - THR_W;

    key_state_e state_q, state_d;
    logic [1:0] flt_q, flt_d;       // {too low, too high}
    logic       pulse_d;

    logic [CNT_W-1:0]        ref_lvl;
    logic signed [SIG_W-1:0] sig_dn, sig_up;
    logic signed [SIG_W-1:0] det_x, rel_x, rise_x;
    logic cnt_hi, cnt_lo, cnt_bad, smp_ok, smp_good;
    logic det_q, rel_q, rise_q;
    logic cal_done, cal_start, tmo_expire;

    logic [RUN_NUM-1:0] run_step, run_qual, run_done;
    logic [RUN_W-1:0]   run_len [RUN_NUM];
    logic               run_clr;

    // signal arithmetic
    assign sig_dn = $signed({1'b0, ref_lvl}) - $signed({1'b0, sample_cnt});
    assign sig_up = $signed({1'b0, sample_cnt}) - $signed({1'b0, ref_lvl});
    assign det_x  = $signed({{PAD_W{1'b0}}, det_thr});
    assign rel_x  = $signed({{PAD_W{1'b0}}, rel_thr});
    assign rise_x = $signed({{PAD_W{1'b0}}, rise_thr});

    assign cnt_hi   = sample_cnt > cnt_max;
    assign cnt_lo   = sample_cnt < cnt_min;
    assign cnt_bad  = cnt_hi || cnt_lo;
    assign smp_ok   = sample_vld && key_en && !recal_req;
    assign smp_good = smp_ok && !cnt_bad;

    assign det_q  = sig_dn > det_x;
    assign rel_q  = sig_dn <= rel_x;
    assign rise_q = sig_up > rise_x;

    // consecutive-sample filters
    assign run_step[RUN_DET]  = smp_good && (state_q == ST_IDLE);
    assign run_step[RUN_REL]  = smp_good && (state_q == ST_TOUCH);
    assign run_step[RUN_RISE] = smp_good && (state_q == ST_IDLE);
    assign run_qual[RUN_DET]  = det_q;
    assign run_qual[RUN_REL]  = rel_q;
    assign run_qual[RUN_RISE] = rise_q;
    assign run_len[RUN_DET]   = det_len;
    assign run_len[RUN_REL]   = rel_len;
    assign run_len[RUN_RISE]  = rise_len;
    assign run_clr = (state_d != state_q) || recal_req;

    for (genvar g = 0; g < RUN_NUM; g++) begin : g_run
        tkf_run_len #(.LEN_W(RUN_W)) u_run (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (run_clr),
            .step (run_step[g]),
            .qual (run_qual[g]),
            .len  (run_len[g]),
            .done (run_done[g])
        );
    end

    assign cal_start = (state_d == ST_CAL) && ((state_q != ST_CAL) || recal_req);

    tkf_ref_track #(.CNT_W(CNT_W), .DIV_W(DIV_W), .CAL_LOG2(CAL_LOG2)) u_ref (
        .clk       (clk),
        .rst_n     (rst_n),
        .cal_start (cal_start),
        .cal_step  (smp_good && (state_q == ST_CAL)),
        .drift_step(smp_good && (state_q == ST_IDLE) && !det_q),
        .drift_clr (smp_good && (state_q == ST_IDLE) && det_q),
        .cnt       (sample_cnt),
        .up_div    (drift_up_div),
        .dn_div    (drift_dn_div),
        .ref_lvl   (ref_lvl),
        .cal_done  (cal_done)
    );

    tkf_on_timer #(.TMO_W(TMO_W)) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_TOUCH),
        .step  (smp_good && (state_q == ST_TOUCH) && !run_done[RUN_REL]),
        .limit (max_on),
        .expire(tmo_expire)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (!key_en) begin
            state_d = ST_OFF;
        end else if (recal_req) begin
            state_d = ST_CAL;
        end else begin
            unique case (state_q)
                ST_OFF: state_d = ST_CAL;
                ST_CAL: begin
                    if (smp_ok && cnt_bad)  state_d = ST_FAULT;
                    else if (cal_done)      state_d = ST_IDLE;
                end
                ST_IDLE: begin
                    if (smp_ok && cnt_bad)       state_d = ST_FAULT;
                    else if (run_done[RUN_DET])  state_d = ST_TOUCH;
                    else if (run_done[RUN_RISE]) state_d = ST_CAL;
                end
                ST_TOUCH: begin
                    if (smp_ok && cnt_bad)      state_d = ST_FAULT;
                    else if (run_done[RUN_REL]) state_d = ST_IDLE;
                    else if (tmo_expire)        state_d = ST_CAL;
                end
                ST_FAULT: state_d = ST_FAULT;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        if (state_d != ST_FAULT)     flt_d = 2'b00;
        else if (state_q == ST_FAULT) flt_d = flt_q;
        else                          flt_d = {cnt_lo, cnt_hi};
    end

    assign pulse_d = key_en && (((state_d == ST_TOUCH) != (state_q == ST_TOUCH)) ||
                                ((state_q == ST_CAL) && (state_d == ST_IDLE)) ||
                                ((state_d == ST_FAULT) && (state_q != ST_FAULT)));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            flt_q   <= 2'b00;
        end else begin
            state_q <= state_d;
            flt_q   <= flt_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            touched      <= 1'b0;
            cal_busy     <= 1'b0;
            err_flags    <= 3'b000;
            change_pulse <= 1'b0;
        end else begin
            touched      <= (state_d == ST_TOUCH);
            cal_busy     <= (state_d == ST_CAL);
            err_flags    <= {flt_d[1], flt_d[0], state_d == ST_CAL};
            change_pulse <= pulse_d;
        end
    end
endmodule

// File: rtl/tkf_checker.sv
module tkf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       key_en,
    input logic       recal_req,
    input logic       sample_vld,
    input logic       touched,
    input logic       cal_busy,
    input logic [2:0] err_flags,
    input logic       change_pulse
);
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !key_en |=> (!touched && !cal_busy && (err_flags == 3'b000) && !change_pulse)); // R1

    AST_CAL_NOT_TOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy |-> (!touched && err_flags[0])); // R2

    AST_RISE_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(touched) |-> change_pulse); // R3

    AST_FALL_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(touched) && $past(key_en)) |-> change_pulse); // R4

    AST_ERR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(err_flags)); // R8

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flags[2] || err_flags[1]) |-> (!touched && !cal_busy)); // R8

    AST_RECAL_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_en && recal_req) |=> cal_busy); // R9

    AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        change_pulse |-> ($past(key_en) && ($past(sample_vld) || $past(recal_req)))); // R10
endmodule

bind touch_key_filter tkf_checker u_tkf_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_en      (key_en),
    .recal_req   (recal_req),
    .sample_vld  (sample_vld),
    .touched     (touched),
    .cal_busy    (cal_busy),
    .err_flags   (err_flags),
    .change_pulse(change_pulse)
);

// File: tb/touch_key_filter_bench.sv
`timescale 1ns/1ps
module touch_key_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_en = 1'b0;
    logic        recal_req = 1'b0;
    logic        sample_vld = 1'b0;
    logic [11:0] sample_cnt = '0;
    logic [7:0]  det_thr = 8'd20, rel_thr = 8'd10, rise_thr = 8'd30;
    logic [3:0]  det_len = 4'd2, rel_len = 4'd1, rise_len = 4'd2;
    logic [7:0]  drift_up_div = 8'd2, drift_dn_div = 8'd4;
    logic [15:0] max_on = 16'd0;
    logic [11:0] cnt_min = 12'd100, cnt_max = 12'd4000;
    logic        touched, cal_busy, change_pulse;
    logic [2:0]  err_flags;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic       t;
        logic       p;
        logic       c;
        logic [2:0] e;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    touch_key_filter u_touch_key_filter (
        .clk(clk), .rst_n(rst_n), .key_en(key_en), .recal_req(recal_req),
        .sample_vld(sample_vld), .sample_cnt(sample_cnt),
        .det_thr(det_thr), .rel_thr(rel_thr), .rise_thr(rise_thr),
        .det_len(det_len), .rel_len(rel_len), .rise_len(rise_len),
        .drift_up_div(drift_up_div), .drift_dn_div(drift_dn_div),
        .max_on(max_on), .cnt_min(cnt_min), .cnt_max(cnt_max),
        .touched(touched), .cal_busy(cal_busy), .err_flags(err_flags),
        .change_pulse(change_pulse)
    );

    task automatic cmp(exp_t x);
        n_chk++;
        if (touched !== x.t || change_pulse !== x.p || cal_busy !== x.c || err_flags !== x.e) begin
            n_bad++;
            $display("FAIL %s: got touched=%0b pulse=%0b cal=%0b err=%03b, expected touched=%0b pulse=%0b cal=%0b err=%03b",
                     x.tag, touched, change_pulse, cal_busy, err_flags, x.t, x.p, x.c, x.e);
        end
    endtask

    task automatic chk(logic t, logic p, logic c, logic [2:0] e, string tag);
        exp_t x;
        x.t = t; x.p = p; x.c = c; x.e = e; x.tag = tag;
        cmp(x);
    endtask

    // driver: one sample per call, expected result queued
    task automatic smp(int cnt, logic t, logic p, logic c, logic [2:0] e, string tag);
        exp_t x;
        @(negedge clk);
        sample_vld = 1'b1;
        sample_cnt = 12'(cnt);
        x.t = t; x.p = p; x.c = c; x.e = e; x.tag = tag;
        sb_q.push_back(x);
        @(negedge clk);
        sample_vld = 1'b0;
    endtask

    task automatic cal8(int cnt, string tag);
        for (int i = 0; i < 7; i++) smp(cnt, 0, 0, 1, 3'b001, tag);
        smp(cnt, 0, 1, 0, 3'b000, tag);
    endtask

    task automatic recal();
        @(negedge clk);
        recal_req = 1'b1;
        @(negedge clk);
        recal_req = 1'b0;
    endtask

    // monitor: compare one cycle after the sampling edge, then check pulse width
    initial begin
        forever begin
            @(posedge clk);
            if (sample_vld) begin
                exp_t x;
                @(negedge clk);
                if (sb_q.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R10: got unexpected sample result, expected queued item");
                end else begin
                    x = sb_q.pop_front();
                    cmp(x);
                    if (x.p) begin
                        @(negedge clk);
                        n_chk++;
                        if (change_pulse !== 1'b0) begin
                            n_bad++;
                            $display("FAIL R10: got pulse=%0b one cycle later, expected 0", change_pulse);
                        end
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got no completion, expected end of sequence");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(0, 0, 0, 3'b000, "R1 reset state");
        smp(1000, 0, 0, 0, 3'b000, "R1 sample ignored while disabled");

        @(negedge clk);
        key_en = 1'b1;
        @(negedge clk);
        chk(0, 0, 1, 3'b001, "R1 enable starts calibration");

        // R2: sum 8004 -> reference 1000
        smp(1000, 0, 0, 1, 3'b001, "R2");
        smp(1001, 0, 0, 1, 3'b001, "R2");
        smp(999,  0, 0, 1, 3'b001, "R2");
        smp(1000, 0, 0, 1, 3'b001, "R2");
        smp(1002, 0, 0, 1, 3'b001, "R2");
        smp(1000, 0, 0, 1, 3'b001, "R2");
        smp(1001, 0, 0, 1, 3'b001, "R2");
        smp(1001, 0, 1, 0, 3'b000, "R2 calibration done");

        // R3: threshold boundary and run restart
        smp(980, 0, 0, 0, 3'b000, "R3 signal equal to threshold");
        smp(980, 0, 0, 0, 3'b000, "R3 signal equal to threshold");
        smp(980, 0, 0, 0, 3'b000, "R3 signal equal to threshold");
        smp(979, 0, 0, 0, 3'b000, "R3 run 1");
        smp(979, 0, 0, 0, 3'b000, "R3 run 2");
        smp(1000, 0, 0, 0, 3'b000, "R3 run broken");
        smp(979, 0, 0, 0, 3'b000, "R3 restarted run 1");
        smp(979, 0, 0, 0, 3'b000, "R3 restarted run 2");
        smp(975, 1, 1, 0, 3'b000, "R3 touch declared");

        // R4: release hysteresis
        smp(990, 1, 0, 0, 3'b000, "R4 release run 1");
        smp(989, 1, 0, 0, 3'b000, "R4 above release threshold");
        smp(995, 1, 0, 0, 3'b000, "R4 release run 1");
        smp(995, 0, 1, 0, 3'b000, "R4 released");

        // R5: fast upward drift -> reference 1001, 980 now detects
        smp(1010, 0, 0, 0, 3'b000, "R5 up drift");
        smp(1010, 0, 0, 0, 3'b000, "R5 up drift");
        smp(980, 0, 0, 0, 3'b000, "R5 raised reference");
        smp(980, 0, 0, 0, 3'b000, "R5 raised reference");
        smp(980, 1, 1, 0, 3'b000, "R5 raised reference detects");
        smp(995, 1, 0, 0, 3'b000, "R5 release");
        smp(995, 0, 1, 0, 3'b000, "R5 release");
        // slow downward drift -> reference back to 1000, 980 no longer detects
        for (int i = 0; i < 4; i++) smp(990, 0, 0, 0, 3'b000, "R5 down drift");
        smp(980, 0, 0, 0, 3'b000, "R5 lowered reference");
        smp(980, 0, 0, 0, 3'b000, "R5 lowered reference");
        smp(980, 0, 0, 0, 3'b000, "R5 lowered reference no touch");
        smp(1000, 0, 0, 0, 3'b000, "R5 equal clears");

        // R6: rise recalibration
        smp(1040, 0, 0, 0, 3'b000, "R6 rise run 1");
        smp(1040, 0, 0, 0, 3'b000, "R6 rise run 2");
        smp(1040, 0, 0, 1, 3'b001, "R6 recalibration, no pulse");
        cal8(2000, "R6 recalibration done");

        // R7: timeout after 3 samples in touch
        max_on = 16'd3;
        smp(1970, 0, 0, 0, 3'b000, "R7 detect");
        smp(1970, 0, 0, 0, 3'b000, "R7 detect");
        smp(1970, 1, 1, 0, 3'b000, "R7 touch");
        smp(1970, 1, 0, 0, 3'b000, "R7 held 1");
        smp(1970, 1, 0, 0, 3'b000, "R7 held 2");
        smp(1970, 0, 1, 1, 3'b001, "R7 timeout recalibrates");
        cal8(2000, "R7 recalibration done");
        max_on = 16'd0;

        // R8: fault high, ignored samples, fault low during calibration
        smp(4001, 0, 1, 0, 3'b010, "R8 count too high");
        smp(2000, 0, 0, 0, 3'b010, "R8 sample ignored in fault");
        recal();
        chk(0, 0, 1, 3'b001, "R9 recalibration clears fault");
        smp(2000, 0, 0, 1, 3'b001, "R8 calibrating");
        smp(2000, 0, 0, 1, 3'b001, "R8 calibrating");
        smp(50, 0, 1, 0, 3'b100, "R8 count too low");
        recal();
        chk(0, 0, 1, 3'b001, "R9 recalibration from fault");
        cal8(2000, "R9 calibration done");

        // R7: infinite hold with max_on 0, then R9 recalibration from touch
        smp(1970, 0, 0, 0, 3'b000, "R7 detect");
        smp(1970, 0, 0, 0, 3'b000, "R7 detect");
        smp(1970, 1, 1, 0, 3'b000, "R7 touch");
        for (int i = 0; i < 20; i++) smp(1970, 1, 0, 0, 3'b000, "R7 infinite hold");
        recal();
        chk(0, 1, 1, 3'b001, "R9 recalibration drops touch with pulse");

        // R1: disable clears without a pulse
        @(negedge clk);
        key_en = 1'b0;
        @(negedge clk);
        chk(0, 0, 0, 3'b000, "R1 disable clears");
        smp(50, 0, 0, 0, 3'b000, "R1 sample ignored when disabled");
        @(negedge clk);
        key_en = 1'b1;
        @(negedge clk);
        chk(0, 0, 1, 3'b001, "R1 re-enable calibrates");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule